// File: doc/BRIEF.md
# Asymmetric Tiled 58x58 Unsigned Multiplier

This block multiplies two unsigned 58-bit operands and returns the exact 116-bit product. It serves double-precision datapaths: a 53-bit significand zero-extended to 58 bits goes in unchanged. The operand pair and a valid flag are sampled together. The product comes out with its own valid flag a fixed number of cycles later. A new pair may be accepted on every clock cycle.

The partial-product board is not cut into a regular grid. Eight 24x17 rectangles cover it, and each one fits a 25x18 signed hardware multiplier that is given unsigned data. A 10x10 square is left over at the centre and has its own small multiplier. The rectangles form two chains of four. Each chain is summed from its far end inwards, and every running sum moves up by 17 bits before the next rectangle is added. The first chain has weight 2^0 and the second has weight 2^24. A final adder combines the two chains with the centre product, which has weight 2^48.

Top module: `tiled_mul58`

## Requirements
- R1: `product_o` equals the exact unsigned product of `x_i` and `y_i` for any two 58-bit operands.
- R2: A pair sampled with `valid_i` high on a rising edge appears on `product_o`, with `valid_o` high, just after the fourth rising edge counting the sampling edge. `valid_o` is high exactly once per accepted pair, and results leave in the order the pairs arrived.
- R3: While `rst_ni` is low, `valid_o` is 0 and `product_o` is all zeros.
- R4: When `valid_o` is low, `product_o` holds the last result it presented.
- R5: Operands whose top five bits are zero (53-bit significands) multiply exactly.
- R6: All-ones operands give the maximum product (2^58-1)^2.
- R7: A zero operand gives a zero product, whatever the other operand is.
- R8: Pairs presented on consecutive cycles each give a correct result on consecutive cycles.
- R9: Each bit of either operand reaches the product at its correct weight. A single set bit at position i, multiplied by an operand v, gives v shifted left by i, for every i from 0 to 57.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair is valid this cycle |
| x_i | input | 58 | Multiplicand, unsigned |
| y_i | input | 58 | Multiplier, unsigned |
| valid_o | output | 1 | Product is valid this cycle |
| product_o | output | 116 | Unsigned product |

## Verification
Every result is due four rising edges after its operands are sampled. The edge that samples the operands counts as the first of the four. When the driver presents a pair half a cycle before a rising edge, it also records the cycle in which the product must appear. The monitor compares `valid_o` and `product_o` half a cycle after each rising edge. A product that comes out early, late, out of order or unexpected is reported as an R2 failure. In the cycles between results, the monitor checks that the output keeps the last product it presented.

// File: rtl/mul58_pkg.sv
package mul58_pkg;
  parameter int OP_W     = 58;
  parameter int WIDE_W   = 24;
  parameter int NARROW_W = 17;
  parameter int HOP      = 17;
  parameter int CORE_W   = 10;
  parameter int GRP_B_SH = 24;
  parameter int CORE_SH  = 48;
  parameter int N_LINK   = 4;
  parameter int N_TILE   = 2 * N_LINK;

  localparam int PROD_W = 2 * OP_W;
  localparam int TILE_W = WIDE_W + NARROW_W;
  localparam int CHAIN_W = TILE_W + (N_LINK - 1) * HOP + 1;
  localparam int CORE_PW = 2 * CORE_W;

  // Slots 0..3 form chain A (base 2^0), slots 4..7 form chain B (base 2^24).
  // Each slot sits HOP bits above the slot before it in the same chain.
  function automatic int tile_xlo(int s);
    case (s)
      0, 1: return 0;
      2:    return 0;
      3:    return 17;
      4:    return 24;
      5:    return 41;
      default: return 34;
    endcase
  endfunction

  function automatic int tile_ylo(int s);
    case (s)
      0: return 0;
      1: return 17;
      2, 3: return 34;
      4, 5: return 0;
      6: return 24;
      default: return 41;
    endcase
  endfunction

  // Each tile is either WIDE x NARROW or NARROW x WIDE.
  function automatic int tile_xw(int s);
    return (s == 2 || s == 3 || s == 4 || s == 5) ? NARROW_W : WIDE_W;
  endfunction

  function automatic int tile_yw(int s);
    return (s == 2 || s == 3 || s == 4 || s == 5) ? WIDE_W : NARROW_W;
  endfunction
endpackage

// File: rtl/mul58_tile.sv
module mul58_tile #(
  parameter int AW = 24,
  parameter int BW = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [AW-1:0]    a_i,
  input  logic [BW-1:0]    b_i,
  output logic [AW+BW-1:0] p_o
);
  localparam int PW = AW + BW;

  logic [PW-1:0] p_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   p_q <= '0;
    else if (en_i) p_q <= PW'(a_i) * PW'(b_i);
  end

  assign p_o = p_q;

  p_tile_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (a_i == '0 || b_i == '0)) |=> (p_o == '0));
endmodule

// File: rtl/mul58_chain.sv
module mul58_chain
  import mul58_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         en_i,
  input  logic [N_LINK-1:0][TILE_W-1:0] p_i,
  output logic [CHAIN_W-1:0]           sum_o
);
  logic [CHAIN_W-1:0] acc;
  logic [CHAIN_W-1:0] sum_q;

  // Innermost first: start at the far link, shift by HOP, add the next.
  always_comb begin
    acc = CHAIN_W'(p_i[N_LINK-1]);
    for (int k = N_LINK - 2; k >= 0; k--) begin
      acc = (acc << HOP) + CHAIN_W'(p_i[k]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sum_q <= '0;
    else if (en_i) sum_q <= acc;
  end

  assign sum_o = sum_q;

  p_chain_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && p_i == '0) |=> (sum_o == '0));
endmodule

// File: rtl/tiled_mul58.sv
module tiled_mul58
  import mul58_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   x_i,
  input  logic [OP_W-1:0]   y_i,
  output logic              valid_o,
  output logic [PROD_W-1:0] product_o
);
  localparam int CORE_LO = WIDE_W;

  // Stage 1: operand capture
  logic            v1_q, v2_q, v3_q, v4_q;
  logic [OP_W-1:0] x_q, y_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      x_q  <= '0;
      y_q  <= '0;
    end else begin
      v1_q <= valid_i;
      if (valid_i) begin
        x_q <= x_i;
        y_q <= y_i;
      end
    end
  end

  // Stage 2: tile products
  logic [N_TILE-1:0][TILE_W-1:0] tile_p;
  logic [CORE_PW-1:0]            core_p;

  for (genvar s = 0; s < N_TILE; s++) begin : g_tile
    localparam int XL = tile_xlo(s);
    localparam int XW = tile_xw(s);
    localparam int YL = tile_ylo(s);
    localparam int YW = tile_yw(s);
    mul58_tile #(.AW(XW), .BW(YW)) u_tile (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (v1_q),
      .a_i    (x_q[XL +: XW]),
      .b_i    (y_q[YL +: YW]),
      .p_o    (tile_p[s])
    );
  end

  mul58_tile #(.AW(CORE_W), .BW(CORE_W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (v1_q),
    .a_i    (x_q[CORE_LO +: CORE_W]),
    .b_i    (y_q[CORE_LO +: CORE_W]),
    .p_o    (core_p)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v2_q <= 1'b0;
    else         v2_q <= v1_q;
  end

  // Stage 3: chain sums, centre delayed alongside
  logic [CHAIN_W-1:0] sum_a, sum_b;
  logic [CORE_PW-1:0] core_q;

  mul58_chain u_chain_a (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (v2_q),
    .p_i    (tile_p[N_LINK-1:0]),
    .sum_o  (sum_a)
  );

  mul58_chain u_chain_b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (v2_q),
    .p_i    (tile_p[N_TILE-1:N_LINK]),
    .sum_o  (sum_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v3_q   <= 1'b0;
      core_q <= '0;
    end else begin
      v3_q <= v2_q;
      if (v2_q) core_q <= core_p;
    end
  end

  // Stage 4: final combine
  logic [PROD_W-1:0] prod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v4_q   <= 1'b0;
      prod_q <= '0;
    end else begin
      v4_q <= v3_q;
      if (v3_q) begin
        prod_q <= PROD_W'(sum_a)
                + (PROD_W'(sum_b) << GRP_B_SH)
                + (PROD_W'(core_q) << CORE_SH);
      end
    end
  end

  assign valid_o   = v4_q;
  assign product_o = prod_q;

  // Edges since reset, saturating, so that the checks below never look back past reset.
  logic [2:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 3'd4) age_q <= age_q + 3'd1;
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 3'd4) |-> (valid_o == $past(valid_i, 4)));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 3'd0 && !valid_o) |-> (product_o == $past(product_o)));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r3: assert (!valid_o && product_o == '0);
    end
  end
endmodule

// File: tb/tb_tiled_mul58.sv
module tb_tiled_mul58;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [57:0]  x_i = '0;
  logic [57:0]  y_i = '0;
  logic         valid_o;
  logic [115:0] product_o;

  always #4 clk_i = ~clk_i;

  tiled_mul58 dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .x_i       (x_i),
    .y_i       (y_i),
    .valid_o   (valid_o),
    .product_o (product_o)
  );

  typedef struct {
    logic [115:0] exp;
    int           due;
    string        req;
  } item_t;

  item_t        sb[$];
  int           cyc = 0;
  int           n_run = 0;
  int           n_fail = 0;
  bit           running = 1'b0;
  bit           have_last = 1'b0;
  bit           finished = 1'b0;
  logic [115:0] last_exp = '0;

  localparam logic [57:0] ONES = {58{1'b1}};

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [57:0] rnd58();
    return {$urandom, $urandom};
  endfunction

  task automatic check(input bit ok, input string req, input logic [115:0] act,
                       input logic [115:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: presents one pair, records the expected product and its due cycle.
  task automatic drive(input logic [57:0] x, input logic [57:0] y, input string req);
    item_t it;
    @(negedge clk_i);
    valid_i = 1'b1;
    x_i = x;
    y_i = y;
    it.exp = {58'b0, x} * {58'b0, y};
    it.due = cyc + 4;
    it.req = req;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      x_i = rnd58();
      y_i = rnd58();
    end
  endtask

  // Monitor
  always @(negedge clk_i) begin
    if (running) begin
      if (valid_o) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2 unexpected valid", product_o, '0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(it.due == cyc, "R2 timing", 116'(cyc), 116'(it.due));
          check(product_o == it.exp, it.req, product_o, it.exp);
          last_exp = it.exp;
          have_last = 1'b1;
        end
      end else begin
        if (have_last) check(product_o == last_exp, "R4 hold", product_o, last_exp);
        if (sb.size() != 0 && sb[0].due <= cyc)
          check(1'b0, "R2 missing result", 116'(cyc), 116'(sb[0].due));
      end
    end
  end

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b0, "R3 valid in reset", 116'(valid_o), '0);
    check(product_o == '0, "R3 product in reset", product_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    running = 1'b1;
    idle(2);

    drive(58'd3, 58'd5, "R1 small");
    drive(rnd58(), rnd58(), "R1 random");
    idle(3);
    drive(ONES, ONES, "R6 all ones");
    idle(5);
    drive('0, rnd58(), "R7 zero x");
    drive(rnd58(), '0, "R7 zero y");
    drive('0, '0, "R7 both zero");
    idle(2);
    for (int i = 0; i < 20; i++) begin
      drive({5'b0, rnd58()[52:0]}, {5'b0, rnd58()[52:0]}, "R5 53-bit");
    end
    drive({5'b0, {53{1'b1}}}, {5'b0, {53{1'b1}}}, "R5 53-bit max");
    idle(4);
    for (int i = 0; i < 58; i++) begin
      drive(58'd1 << i, rnd58(), "R9 walk x");
      drive(rnd58(), 58'd1 << i, "R9 walk y");
    end
    drive(ONES, 58'd1 << 57, "R9 top bit");
    idle(6);
    for (int i = 0; i < 40; i++) begin
      drive(rnd58(), rnd58(), "R8 back-to-back");
    end
    idle(3);
    for (int i = 0; i < 30; i++) begin
      drive(rnd58(), ONES, "R1 gapped");
      idle(i % 3);
    end
    idle(8);
    check(sb.size() == 0, "R2 drained", 116'(sb.size()), '0);
    finished = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      report();
    end
  end
endmodule